// File: doc/BRIEF.md
# Life Cell Next-State Evaluator

This block computes the next state of one cell in a two-dimensional Life automaton. Its input is a snapshot of the cell and its eight surrounding cells, packed into a 9-bit word. Its output is a single bit that says whether the centre cell is live in the next generation. The block counts the live cells around the centre and applies the birth and survival rule to that count and to the centre bit.

The evaluator has no clock and no state. It is meant to be instanced many times inside larger grid evaluators. Each instance receives a window of the grid cut out by its parent. Edge handling, storage of the grid and the sequencing of generations all stay with that parent. The result settles within the same cycle as the input, so a parent can register it wherever its own timing requires.

Top module: `life_cell_next`

## Requirements
- R1: Each input bit means a live cell when it is 1 and a dead cell when it is 0. An all-zero window gives output 0.
- R2: The window is packed by rows. Bits 0, 1 and 2 hold the top row from left to right, bits 3, 4 and 5 hold the middle row, and bits 6, 7 and 8 hold the bottom row. Bit 4 is the centre cell.
- R3: A dead centre (bit 4 = 0) gives output 1 only when exactly 3 of its neighbours are live.
- R4: Exactly 3 live neighbours give output 1, whatever the centre bit is.
- R5: Exactly 2 live neighbours give an output equal to the centre bit.
- R6: Fewer than 2 live neighbours, or more than 3, give output 0, whatever the centre bit is.
- R7: The centre bit is never counted as a neighbour. A live centre with 2 live neighbours gives 1, and a dead centre with 2 live neighbours gives 0.
- R8: Each of the eight neighbour positions (bits 0, 1, 2, 3, 5, 6, 7 and 8) carries equal weight in the count. The output for every one of the 512 input values matches a model that counts neighbours one position at a time.
- R9: The output is a combinational function of the current input only. A change of input shows on the output before the next clock edge, with no reset needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| nbhd_i | input | 9 | 3x3 window packed by rows, centre at bit 4, 1 = live |
| next_o | output | 1 | Next state of the centre cell, 1 = live |

## Verification
The cases hardest to tell apart from the ports are those where the count lands exactly on 2. There, the output must follow the centre bit. A design that wrongly includes the centre in the count gives the same result for most other patterns. The other hard case is a count of 8, which only fills the top value of the counter with all neighbours live.

The stimulus sweeps all 512 window values. This covers every count from 0 to 8 for both centre states, and every placement of the neighbours. Directed patterns for the count-of-2 pairs, the count of 3 with a live centre, and the full window are also applied, so that these cases carry their own requirement tags.

// File: rtl/life_pkg.sv
package life_pkg;
  // Side length of the square window and derived sizes.
  localparam int SIDE   = 3;
  localparam int CELLS  = SIDE * SIDE;
  localparam int CENTER = CELLS / 2;
  localparam int CNT_W  = $clog2(CELLS);

  // Rule thresholds: born on BIRTH, survive on SURV_LO..SURV_HI.
  localparam int BIRTH   = 3;
  localparam int SURV_LO = 2;
  localparam int SURV_HI = 3;

  typedef logic [CELLS-1:0] window_t;
  typedef logic [CNT_W-1:0] count_t;
endpackage

// File: rtl/life_nbr_count.sv
// Population count of a window with one position (the centre) masked out.
module life_nbr_count #(
  parameter int WIDTH = 9,
  parameter int SKIP  = 4,
  parameter int CW    = 4
) (
  input  logic [WIDTH-1:0] cells_i,
  output logic [CW-1:0]    count_o
);
  logic [WIDTH-1:0] masked;

  // Build the masked vector position by position.
  for (genvar g = 0; g < WIDTH; g++) begin : g_mask
    if (g == SKIP) begin : g_centre
      assign masked[g] = 1'b0;
    end else begin : g_nbr
      assign masked[g] = cells_i[g];
    end
  end

  always_comb begin
    count_o = '0;
    for (int i = 0; i < WIDTH; i++) begin
      count_o = count_o + CW'(masked[i]);
    end
  end
endmodule

// File: rtl/life_rule.sv
// Applies the birth / survival rule to a neighbour count and the centre bit.
module life_rule #(
  parameter int CW      = 4,
  parameter int BIRTH   = 3,
  parameter int SURV_LO = 2,
  parameter int SURV_HI = 3
) (
  input  logic [CW-1:0] count_i,
  input  logic          alive_i,
  output logic          next_o
);
  logic born;
  logic keeps;

  always_comb begin
    born   = (count_i == CW'(BIRTH));
    keeps  = (count_i >= CW'(SURV_LO)) && (count_i <= CW'(SURV_HI));
    next_o = alive_i ? keeps : born;
  end
endmodule

// File: rtl/life_cell_next.sv
// Top: next state of the centre cell of a 3x3 window.
module life_cell_next (
  input  logic [life_pkg::CELLS-1:0] nbhd_i,
  output logic                       next_o
);
  import life_pkg::*;

  count_t nbr_cnt;
  logic   centre;

  assign centre = nbhd_i[CENTER];

  life_nbr_count #(
    .WIDTH (CELLS),
    .SKIP  (CENTER),
    .CW    (CNT_W)
  ) count_i (
    .cells_i (nbhd_i),
    .count_o (nbr_cnt)
  );

  life_rule #(
    .CW      (CNT_W),
    .BIRTH   (BIRTH),
    .SURV_LO (SURV_LO),
    .SURV_HI (SURV_HI)
  ) rule_i (
    .count_i (nbr_cnt),
    .alive_i (centre),
    .next_o  (next_o)
  );
endmodule

// File: rtl/life_cell_next_chk.sv
// Port-level checks for life_cell_next, bound onto every instance.
module life_cell_next_chk (
  input logic [8:0] nbhd_i,
  input logic       next_o
);
  int nb;

  always_comb begin
    nb = $countones(nbhd_i & 9'b1_1110_1111);
    // R4: three live neighbours always give a live cell
    assert_birth3_R4: assert (nb != 3 || next_o == 1'b1)
      else $error("R4 violated: in=%b out=%b", nbhd_i, next_o);
    // R5: two live neighbours hold the centre state
    assert_hold2_R5: assert (nb != 2 || next_o == nbhd_i[4])
      else $error("R5 violated: in=%b out=%b", nbhd_i, next_o);
    // R6: under- or over-population kills
    assert_die_R6: assert (!(nb < 2 || nb > 3) || next_o == 1'b0)
      else $error("R6 violated: in=%b out=%b", nbhd_i, next_o);
    // R3: a dead centre is born only on exactly three
    assert_dead_born_R3: assert (!(next_o && !nbhd_i[4]) || nb == 3)
      else $error("R3 violated: in=%b out=%b", nbhd_i, next_o);
  end
endmodule

bind life_cell_next life_cell_next_chk chk_i (.nbhd_i(nbhd_i), .next_o(next_o));

// File: tb/life_cell_next_tb_top.sv
module life_cell_next_tb_top;
  logic       clk = 1'b0;
  logic [8:0] nbhd;
  logic       next_s;
  int         n_cmp = 0;
  int         n_bad = 0;
  int         cycles = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  life_cell_next dut_i (.nbhd_i(nbhd), .next_o(next_s));

  function automatic int ref_count(logic [8:0] w);
    int c = 0;
    for (int r = 0; r < 3; r++)
      for (int k = 0; k < 3; k++)
        if (!(r == 1 && k == 1) && w[r*3+k]) c++;
    return c;
  endfunction

  function automatic logic ref_next(logic [8:0] w);
    int c = ref_count(w);
    if (w[4]) return (c == 2 || c == 3);
    return (c == 3);
  endfunction

  task automatic check(string req, logic [8:0] w, logic exp);
    @(negedge clk);
    nbhd = w;
    @(posedge clk);
    #1;
    n_cmp++;
    if (next_s !== exp) begin
      n_bad++;
      $display("FAIL %s in=%b actual=%b expected=%b", req, w, next_s, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    nbhd = '0;
    // R1: empty window
    check("R1", 9'b000000000, 1'b0);
    // R7: centre excluded; count 2 with live/dead centre
    check("R7", 9'b000010011, 1'b1);
    check("R7", 9'b000000011, 1'b0);
    // R5: count 2, bottom row corners
    check("R5", 9'b101010000, 1'b1);
    check("R5", 9'b101000000, 1'b0);
    // R4: count 3 with live centre and dead centre
    check("R4", 9'b000111001, 1'b1);
    check("R4", 9'b000101001, 1'b1);
    // R2: row layout -- bits 3 and 5 are middle row, left and right
    check("R2", 9'b000101100, 1'b1);
    // R6: four neighbours kill a live centre; full window dies
    check("R6", 9'b000011111, 1'b0);
    check("R6", 9'b111111111, 1'b0);
    check("R6", 9'b000010001, 1'b0);
    // R3: dead centre with 2 and with 4 stays dead
    check("R3", 9'b100000001, 1'b0);
    check("R3", 9'b100100101, 1'b0);
    // R9: output follows a new input within the same cycle
    check("R9", 9'b000000111, 1'b1);
    check("R9", 9'b000000110, 1'b0);
    // R8: exhaustive sweep against the counting model
    for (int v = 0; v < 512; v++) begin
      check("R8", v[8:0], ref_next(v[8:0]));
    end
    finish_run();
  end
endmodule